// File: doc/BRIEF.md
# Byte-Lane Write Responder for a Strobe/Acknowledge Bus

This block is the slave side of an asynchronous 32-bit bus. The master marks a transfer with an active-low address strobe and an active-low data strobe. It also drives a read/write line, a two-bit transfer size and an address. The block brings both strobes into its clock domain through two-flop synchronisers. Once both show as asserted, it starts a transfer. On a write it stores the selected bytes of the data bus into the addressed word of a small internal register file.

After a programmable number of clocks the block drives its two-bit acknowledge low. This makes it look like a full 32-bit port, and the delay lets a master's wait-state logic be exercised. The acknowledge stays low for as long as both strobes stay low. When the synchronised view shows either strobe released, the block lifts the acknowledge one clock later.

A combinational peek port shows any stored word to the neighbouring logic.

Top module: `strobe_lane_slave`

## Requirements
- R1: After reset the acknowledge output is 2'b11 and every stored word reads 0.
- R2: Byte offset k (address bits 1:0) names data-bus byte lane D[31-8k -: 8]. Offset 0 is D31..D24 and offset 3 is D7..D0. A write stores only its enabled lanes, each into the same byte position of the stored word.
- R3: Size code 2'b01 moves one byte, 2'b10 two, 2'b11 three and 2'b00 four. The enabled lanes run from the addressed offset toward offset 3 and stop at offset 3.
- R4: Address bits above bit 1 select the stored word. No other word changes.
- R5: A read (rw=1) is acknowledged with normal timing and changes no stored word.
- R6: The two acknowledge bits are always equal.
- R7: If a strobe is driven low just after a rising edge and both strobes are then low, the acknowledge reads low after exactly 3+lat_cfg rising edges.
- R8: The acknowledge stays low while both strobes stay low.
- R9: If either strobe is driven high just after a rising edge while the acknowledge is low, the acknowledge reads 2'b11 after exactly 3 rising edges.
- R10: If a strobe is released before the latency has run out, no acknowledge is given for that transfer. A write started that way has already been stored.
- R11: A data strobe with the address strobe high starts nothing: no acknowledge and no stored change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rw | input | 1 | 1 = read, 0 = write |
| siz | input | 2 | Transfer size code |
| addr | input | 2+clog2(NUM_WORDS) | Word select in the upper bits, byte offset in bits 1:0 |
| wdata | input | 32 | Write data bus |
| lat_cfg | input | LAT_W | Clocks between detection and acknowledge |
| ack_n | output | 2 | Data-size acknowledge, active low |
| peek_idx | input | clog2(NUM_WORDS) | Word to show on peek_data |
| peek_data | output | 32 | Contents of word peek_idx |

## Verification
The storage write and the raising of the acknowledge happen on the same clock edge when lat_cfg is 0. The bench runs zero-latency writes and then checks two things: that the acknowledge arrives after exactly three edges, and that the peek port already shows the merged word. The second overlap is a strobe release that lands inside the latency window, while the block is waiting to acknowledge. The bench expects no acknowledge in that case, and it expects the write made at detection to stay stored.

// File: rtl/strobe_pkg.sv
// Shared constants, state type and lane-mask function for the strobe slave.
// Assumes a fixed 32-bit port of four byte lanes; lane 3 is D31..D24.
package strobe_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } hs_state_t;

    // Lane enables for size code and byte offset; offset 0 maps to lane 3.
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size_code,
                                                   input logic [1:0] offset);
        logic [2:0] count;
        logic [3:0] first;
        logic [3:0] last;
        logic [LANES-1:0] mask;
        count = (size_code == 2'b00) ? 3'd4 : {1'b0, size_code};
        first = {2'b00, offset};
        last  = first + {1'b0, count} - 4'd1;
        mask  = '0;
        for (int k = 0; k < LANES; k++) begin
            if ((4'(k) >= first) && (4'(k) <= last))
                mask[LANES-1-k] = 1'b1;
        end
        return mask;
    endfunction
endpackage

// File: rtl/strobe_sync.sv
// Two-flop synchroniser bank for active-low asynchronous strobes.
// Assumes each bit is independent; flops reset to the negated level (1).
module strobe_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            // Move one strobe bit through two flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1[g] <= 1'b1;
                    stage2[g] <= 1'b1;
                end else begin
                    stage1[g] <= async_n[g];
                    stage2[g] <= stage1[g];
                end
            end
        end
    endgenerate

    assign sync_n = stage2;
endmodule

// File: rtl/lane_decoder.sv
// Turns size code, byte offset and direction into per-lane write enables.
// Assumes the caller qualifies the result with the transfer-start pulse.
module lane_decoder
    import strobe_pkg::*;
(
    input  logic             start,
    input  logic             rw,
    input  logic [1:0]       siz,
    input  logic [1:0]       offset,
    output logic [LANES-1:0] lane_we
);
    // Enable lanes only for a starting write.
    always_comb begin
        lane_we = '0;
        if (start && !rw)
            lane_we = lane_mask(siz, offset);
    end
endmodule

// File: rtl/byte_regfile.sv
// Small word-addressed register file with one write enable per byte lane
// and a combinational peek port. Assumes NUM_WORDS >= 2.
module byte_regfile
    import strobe_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    localparam int IDX_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data
);
    logic [BYTE_W-1:0] mem [NUM_WORDS][LANES];

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Store one byte lane of the addressed word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int w = 0; w < NUM_WORDS; w++)
                        mem[w][l] <= '0;
                end else if (lane_we[l]) begin
                    mem[wr_idx][l] <= wr_data[l*BYTE_W +: BYTE_W];
                end
            end

            assign peek_data[l*BYTE_W +: BYTE_W] = mem[peek_idx][l];
        end
    endgenerate
endmodule

// File: rtl/handshake_fsm.sv
// Transfer sequencer: detects both synchronised strobes, waits lat_cfg
// clocks, drives the acknowledge, then drops it one clock after either
// strobe is seen released. Assumes strobe inputs are already synchronised.
module handshake_fsm
    import strobe_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_s_n,
    input  logic             ds_s_n,
    input  logic [LAT_W-1:0] lat_cfg,
    output logic             start,
    output logic [1:0]       ack_n
);
    hs_state_t        state;
    logic [LAT_W-1:0] wait_cnt;
    logic             both_on;

    assign both_on = !as_s_n && !ds_s_n;
    assign start   = (state == ST_IDLE) && both_on;

    // Step the handshake state and the acknowledge register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            ack_n    <= 2'b11;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (both_on) begin
                        wait_cnt <= lat_cfg;
                        if (lat_cfg == '0) begin
                            state <= ST_ACK;
                            ack_n <= 2'b00;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!both_on) begin
                        state <= ST_IDLE;
                    end else if (wait_cnt == LAT_W'(1)) begin
                        state <= ST_ACK;
                        ack_n <= 2'b00;
                    end else begin
                        wait_cnt <= wait_cnt - LAT_W'(1);
                    end
                end
                ST_ACK: begin
                    if (!both_on) begin
                        state <= ST_IDLE;
                        ack_n <= 2'b11;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    ack_n <= 2'b11;
                end
            endcase
        end
    end
endmodule

// File: rtl/strobe_lane_slave.sv
// Top of the byte-lane write responder. Synchronises the strobes, sequences
// the handshake, decodes lanes and stores write data. Assumes the master
// holds rw, siz, addr and wdata stable while its strobes are asserted.
module strobe_lane_slave
    import strobe_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int LAT_W     = 3,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int ADDR_W   = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [1:0]        siz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LAT_W-1:0]  lat_cfg,
    output logic [1:0]        ack_n,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] peek_data
);
    logic [1:0]       strobes_s_n;
    logic             start;
    logic [LANES-1:0] lane_we;

    strobe_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n ({as_n, ds_n}),
        .sync_n  (strobes_s_n)
    );

    handshake_fsm #(.LAT_W(LAT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_s_n  (strobes_s_n[1]),
        .ds_s_n  (strobes_s_n[0]),
        .lat_cfg (lat_cfg),
        .start   (start),
        .ack_n   (ack_n)
    );

    lane_decoder u_dec (
        .start   (start),
        .rw      (rw),
        .siz     (siz),
        .offset  (addr[1:0]),
        .lane_we (lane_we)
    );

    byte_regfile #(.NUM_WORDS(NUM_WORDS)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .wr_idx    (addr[ADDR_W-1:2]),
        .wr_data   (wdata),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );
endmodule

// File: rtl/strobe_lane_slave_chk.sv
// Property checker for strobe_lane_slave, attached by bind below.
// Assumes lat_cfg is held stable across a transfer.
module strobe_lane_slave_chk #(
    parameter int LAT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             as_n,
    input logic             ds_n,
    input logic [LAT_W-1:0] lat_cfg,
    input logic             start,
    input logic [1:0]       ack_n
);
    logic [LAT_W:0] since_start;

    // Count clocks since the last transfer start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_start <= '0;
        else if (start)
            since_start <= '0;
        else if (since_start != '1)
            since_start <= since_start + 1'b1;
    end

    // R6: both acknowledge bits move together.
    a_r6_ack_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n[0] == ack_n[1]);

    // R9: address strobe high for three samples forces the acknowledge off.
    a_r9_as_release: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n && $past(as_n) && $past(as_n, 2)) |=> (ack_n == 2'b11));

    // R9: data strobe high for three samples forces the acknowledge off.
    a_r9_ds_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_n && $past(ds_n) && $past(ds_n, 2)) |=> (ack_n == 2'b11));

    // R11: an acknowledge only begins after both strobes were low.
    a_r11_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_n == 2'b00) && ($past(ack_n) == 2'b11)) |->
            (!$past(as_n, 3) && !$past(ds_n, 3)));

    // R7: the acknowledge begins lat_cfg clocks after transfer start.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_n == 2'b00) && ($past(ack_n) == 2'b11)) |->
            (since_start == {1'b0, lat_cfg}));
endmodule

bind strobe_lane_slave strobe_lane_slave_chk #(.LAT_W(LAT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (as_n),
    .ds_n    (ds_n),
    .lat_cfg (lat_cfg),
    .start   (start),
    .ack_n   (ack_n)
);

// File: tb/test_strobe_lane_slave.sv
// Bench for strobe_lane_slave: directed size/offset sweep, corner cases and
// seeded random writes/reads, checked against a byte-merge model.
module test_strobe_lane_slave;
    localparam int NW = 8;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rw = 1'b1;
    logic [1:0]  siz = 2'b00;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  lat_cfg = '0;
    logic [1:0]  ack_n;
    logic [2:0]  peek_idx = '0;
    logic [31:0] peek_data;

    logic [31:0] model [NW];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strobe_lane_slave #(.NUM_WORDS(NW), .LAT_W(3)) i_strobe_lane_slave (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .siz(siz), .addr(addr), .wdata(wdata), .lat_cfg(lat_cfg),
        .ack_n(ack_n), .peek_idx(peek_idx), .peek_data(peek_data)
    );

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [1:0] sz, input logic [1:0] off);
        int n;
        logic [31:0] r;
        n = (sz == 2'b00) ? 4 : int'(sz);
        r = old;
        for (int i = int'(off); i < int'(off) + n && i < 4; i++)
            r[31-8*i -: 8] = d[31-8*i -: 8];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_words(input string tag);
        for (int w = 0; w < NW; w++) begin
            peek_idx = IW'(w);
            #1;
            check(tag, peek_data, model[w]);
        end
    endtask

    // Full handshake: returns after both strobes are released.
    task automatic bus_cycle(input logic r, input int word, input logic [1:0] sz,
                             input logic [1:0] off, input logic [31:0] d,
                             input logic [2:0] lat, input bit drop_as);
        int n;
        @(negedge clk);
        lat_cfg = lat; rw = r; siz = sz; addr = {IW'(word), off}; wdata = d;
        as_n = 1'b0;
        @(negedge clk);
        ds_n = 1'b0;
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (ack_n != 2'b00 && n < 20);
        check("R7 ack latency", n, 3 + lat);
        check("R6 ack pair", {30'd0, ack_n}, 32'd0);
        if (!r) model[word] = merge(model[word], d, sz, off);
        @(negedge clk); @(negedge clk);
        check("R8 ack held", {30'd0, ack_n}, 32'd0);
        if (drop_as) as_n = 1'b1; else ds_n = 1'b1;
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (ack_n != 2'b11 && n < 20);
        check("R9 release", n, 3);
        as_n = 1'b1; ds_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int w = 0; w < NW; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ack", {30'd0, ack_n}, 32'h3);
        check_words("R1 reset words");

        // R2 R3 R4: every size/offset combination, zero latency.
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++) begin
                bus_cycle(1'b0, (s * 4 + o) % NW, 2'(s), 2'(o), $urandom, 3'd0, 1'b0);
                check_words("R2 R3 R4 lane sweep");
            end

        // R5: read leaves storage alone.
        bus_cycle(1'b1, 2, 2'b00, 2'b00, 32'hFFFF_FFFF, 3'd2, 1'b1);
        check_words("R5 read no store");

        // R10: strobe drops during latency window.
        @(negedge clk);
        lat_cfg = 3'd6; rw = 1'b0; siz = 2'b00; addr = {3'd5, 2'b00}; wdata = 32'hA5C3_0F1E;
        as_n = 1'b0; ds_n = 1'b0;
        model[5] = 32'hA5C3_0F1E;
        repeat (4) @(negedge clk);
        ds_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R10 no ack after abort", {30'd0, ack_n}, 32'h3);
        end
        as_n = 1'b1;
        repeat (3) @(negedge clk);
        check_words("R10 write kept");

        // R11: data strobe alone.
        @(negedge clk);
        lat_cfg = 3'd0; rw = 1'b0; siz = 2'b00; addr = {3'd1, 2'b00}; wdata = 32'hDEAD_BEEF;
        ds_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R11 no ack", {30'd0, ack_n}, 32'h3);
        end
        ds_n = 1'b1;
        repeat (3) @(negedge clk);
        check_words("R11 no store");

        // Random mix of writes and reads, all latencies, both release orders.
        for (int t = 0; t < 60; t++) begin
            bus_cycle(1'(($urandom % 4) == 0), int'($urandom % NW), 2'($urandom), 2'($urandom),
                      $urandom, 3'($urandom), 1'($urandom));
            check_words("R2 R3 R4 R5 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule